// File: doc/BRIEF.md
# RAM Ownership Grant Controller with Erase

This controller hands a group of shareable RAMs to one privileged context, and takes them back, under software control. Software asks for ownership by writing a write-1-to-set request bit. Before the grant takes effect, the controller always erases the RAMs. It fires a start strobe to the RAM initialization sequencer and waits until every RAM has reported completion. Only then does it raise the grant status that the access-protection logic uses.

Giving ownership back uses a second write-1-to-set request bit. An erase runs before the release only if software has armed a wipe-on-release flag. That flag clears itself when the release completes.

While an erase is running, the block ignores new requests and shows a busy flag. The register view has three word slots, selected by index:

- Status (index 0): the grant bit.
- Force (index 1): the open request and the wipe flag.
- Release (index 2): the release request.

Top module: `ram_own_ctrl`

## Requirements
- R1: After the asynchronous reset, granted_o, busy_o and init_start_o are 0, and the wipe flag is 0.
- R2: A 1 written to bit 8 of the force slot while not granted raises init_start_o for exactly one cycle and raises busy_o. granted_o rises only on the edge at which every bit of init_done_i has been seen. Done pulses may arrive in any order, one at a time or together.
- R3: Writing 0 to the open or release request bit has no effect, and so does writing to any other non-field bit. The open request bit and the release request bit always read back as 0.
- R4: Writing 1 to bit 12 of the force slot sets the wipe flag, which reads back at that bit. Writing 0 there does not clear it.
- R5: A 1 written to bit 1 of the release slot while granted, with the wipe flag clear, drops granted_o on the next edge and starts no erase.
- R6: A release request while granted, with the wipe flag set, starts an erase. granted_o stays 1 until every RAM has reported done, then falls.
- R7: The wipe flag is cleared when an accepted release request completes. This includes a release request made while already not granted.
- R8: The grant state reads back at bit 1 of the status slot (0 means normal protection, 1 means owned by the privileged context).
- R9: While busy_o is 1, open and release requests are ignored, and no new start strobe is issued.
- R10: An open request while already granted, or a release request while not granted, completes without an erase.
- R11: If open and release requests arrive in the same cycle, the open request is taken and the release request is dropped.
- R12: Done pulses that arrive while no erase is running are not counted toward the next erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_sel_i | input | NUM_SLOTS | One-hot-or-more write strobe, one bit per register slot |
| wr_data_i | input | DATA_W | Write data shared by all selected slots |
| rd_addr_i | input | ADDR_W | Read slot index |
| rd_data_o | output | DATA_W | Read data of the addressed slot (combinational) |
| init_start_o | output | 1 | One-cycle start strobe to the RAM initialization sequencer |
| init_done_i | input | NUM_RAMS | Per-RAM initialization done pulses |
| busy_o | output | 1 | Erase in progress |
| granted_o | output | 1 | RAMs owned by the privileged context |

## Verification
The checker watches every cycle for the following:

- The start strobe lasts one cycle and never occurs without busy.
- No second strobe starts inside an erase.
- The grant can only rise after an erase.
- The grant holds steady for the whole of an erase.
- The wipe flag only falls when the grant is low.

Only the bench scenarios can show the rest: which request/state/flag combinations start an erase, the final grant and flag values for each, the set-over-release priority, completion only after all RAMs report in arbitrary orders, and the discarding of stale done pulses.

// File: rtl/ram_own_pkg.sv
package ram_own_pkg;
  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned SLOT_STAT  = 0;
  localparam int unsigned SLOT_FORCE = 1;
  localparam int unsigned SLOT_CLEAR = 2;

  // bit positions decoded by software
  localparam int unsigned BIT_GRANT = 1;
  localparam int unsigned BIT_OPEN  = 8;
  localparam int unsigned BIT_WIPE  = 12;
  localparam int unsigned BIT_CLOSE = 1;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_OPEN_WIPE  = 2'd1,
    ST_CLOSE_WIPE = 2'd2
  } own_state_e;
endpackage

// File: rtl/ram_own_req_dec.sv
module ram_own_req_dec
  import ram_own_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [NUM_SLOTS-1:0] wr_sel_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic                 open_req_o,
  output logic                 close_req_o,
  output logic                 wipe_set_o
);
  logic unused_data;
  assign unused_data = ^wr_data_i;

  assign open_req_o  = wr_sel_i[SLOT_FORCE] & wr_data_i[BIT_OPEN];
  assign wipe_set_o  = wr_sel_i[SLOT_FORCE] & wr_data_i[BIT_WIPE];
  assign close_req_o = wr_sel_i[SLOT_CLEAR] & wr_data_i[BIT_CLOSE];
endmodule

// File: rtl/ram_own_done_collect.sv
module ram_own_done_collect #(
  parameter int unsigned NUM_RAMS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                active_i,
  input  logic [NUM_RAMS-1:0] done_i,
  output logic                all_done_o
);
  logic [NUM_RAMS-1:0] seen_q;

  for (genvar g = 0; g < NUM_RAMS; g++) begin : g_ram
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   seen_q[g] <= 1'b0;
      else if (restart_i)            seen_q[g] <= 1'b0;
      else if (active_i && done_i[g]) seen_q[g] <= 1'b1;
    end
  end

  // stale pulses never land in seen_q, so gating with active_i is enough
  assign all_done_o = active_i & (&(seen_q | done_i));
endmodule

// File: rtl/ram_own_fsm.sv
module ram_own_fsm
  import ram_own_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_req_i,
  input  logic close_req_i,
  input  logic wipe_set_i,
  input  logic all_done_i,
  output logic start_o,
  output logic restart_o,
  output logic busy_o,
  output logic granted_o,
  output logic wipe_o
);
  own_state_e state_q, state_d;
  logic       grant_q, grant_d;
  logic       wipe_q, wipe_d;
  logic       start_q, start_d;
  logic       close_done;

  always_comb begin
    state_d    = state_q;
    grant_d    = grant_q;
    start_d    = 1'b0;
    close_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (open_req_i) begin
          if (!grant_q) begin
            state_d = ST_OPEN_WIPE;
            start_d = 1'b1;
          end
        end else if (close_req_i) begin
          if (grant_q && wipe_q) begin
            state_d = ST_CLOSE_WIPE;
            start_d = 1'b1;
          end else begin
            grant_d    = 1'b0;
            close_done = 1'b1;
          end
        end
      end
      ST_OPEN_WIPE: begin
        if (all_done_i) begin
          grant_d = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_CLOSE_WIPE: begin
        if (all_done_i) begin
          grant_d    = 1'b0;
          close_done = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // completion clear beats a simultaneous arm
  always_comb begin
    wipe_d = wipe_q;
    if (close_done)      wipe_d = 1'b0;
    else if (wipe_set_i) wipe_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grant_q <= 1'b0;
      wipe_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
      wipe_q  <= wipe_d;
      start_q <= start_d;
    end
  end

  assign start_o   = start_q;
  assign restart_o = start_d;
  assign busy_o    = (state_q != ST_IDLE);
  assign granted_o = grant_q;
  assign wipe_o    = wipe_q;
endmodule

// File: rtl/ram_own_rd_mux.sv
module ram_own_rd_mux
  import ram_own_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              granted_i,
  input  logic              wipe_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_W'(SLOT_STAT):  rd_data_o[BIT_GRANT] = granted_i;
      ADDR_W'(SLOT_FORCE): rd_data_o[BIT_WIPE]  = wipe_i;
      default:             rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/ram_own_ctrl.sv
module ram_own_ctrl
  import ram_own_pkg::*;
#(
  parameter int unsigned NUM_RAMS = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] wr_sel_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 init_start_o,
  input  logic [NUM_RAMS-1:0]  init_done_i,
  output logic                 busy_o,
  output logic                 granted_o
);
  logic open_req, close_req, wipe_set;
  logic all_done, restart, wipe_flag;

  ram_own_req_dec #(.DATA_W(DATA_W)) u_dec (
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .open_req_o  (open_req),
    .close_req_o (close_req),
    .wipe_set_o  (wipe_set)
  );

  ram_own_done_collect #(.NUM_RAMS(NUM_RAMS)) u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .active_i   (busy_o),
    .done_i     (init_done_i),
    .all_done_o (all_done)
  );

  ram_own_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_req_i  (open_req),
    .close_req_i (close_req),
    .wipe_set_i  (wipe_set),
    .all_done_i  (all_done),
    .start_o     (init_start_o),
    .restart_o   (restart),
    .busy_o      (busy_o),
    .granted_o   (granted_o),
    .wipe_o      (wipe_flag)
  );

  ram_own_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rd_addr_i (rd_addr_i),
    .granted_i (granted_o),
    .wipe_i    (wipe_flag),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/ram_own_ctrl_chk.sv
module ram_own_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic init_start_o,
  input logic busy_o,
  input logic granted_o,
  input logic wipe_flag
);
  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_start_o |=> !init_start_o);

  assert_grant_after_erase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(granted_o) |-> $past(busy_o));

  assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_start_o |-> busy_o);

  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> !init_start_o);

  assert_grant_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(granted_o));

  assert_wipe_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wipe_flag) |-> !granted_o);
endmodule

bind ram_own_ctrl ram_own_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .init_start_o (init_start_o),
  .busy_o       (busy_o),
  .granted_o    (granted_o),
  .wipe_flag    (wipe_flag)
);

// File: tb/ram_own_ctrl_tb.sv
`timescale 1ns/1ps
module ram_own_ctrl_tb;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [31:0] B_OPEN  = 32'h0000_0100;
  localparam logic [31:0] B_WIPE  = 32'h0000_1000;
  localparam logic [31:0] B_CLOSE = 32'h0000_0002;
  localparam logic [2:0]  S_FORCE = 3'b010;
  localparam logic [2:0]  S_CLEAR = 3'b100;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          init_start;
  logic [N-1:0]  init_done = '0;
  logic          busy, granted;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ram_own_ctrl #(.NUM_RAMS(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .init_start_o(init_start),
    .init_done_i(init_done), .busy_o(busy), .granted_o(granted)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_sel = '0; init_done = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [31:0] d);
    wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_sel = '0; wr_data = '0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    init_done = m;
    @(negedge clk);
    init_done = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rd_addr = AW'(a);
    #0.1;
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    check("R1 granted", 32'(granted), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 start", 32'(init_start), 0);
    rd(1, v); check("R1 wipe", v, 0);

    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        for (int op = 0; op < 4; op++) begin
          int k;
          bit exp_init, exp_open, exp_wipe;
          string tag;
          k = s * 8 + w * 4 + op;
          do_reset();
          if (s == 1) begin
            do_write(S_FORCE, B_OPEN);
            pulse('1);
            check("R2 setup grant", 32'(granted), 1);
          end
          if (w == 1) do_write(S_FORCE, B_WIPE);
          rd(1, v); check("R4 wipe armed", v, w ? B_WIPE : 0);

          exp_init = ((op == 0 || op == 2) && s == 0) || (op == 1 && s == 1 && w == 1);
          exp_open = (op == 0 || op == 2) ? 1'b1 : (op == 1) ? 1'b0 : s[0];
          exp_wipe = (op == 1) ? 1'b0 : w[0];
          case (op)
            0: tag = s ? "R10 open-when-open" : "R2 open";
            1: tag = !s ? "R7 close-when-closed" : (w ? "R6 close-wipe" : "R5 close-nowipe");
            2: tag = "R11 open+close";
            default: tag = "R3 zero writes";
          endcase

          case (op)
            0: do_write(S_FORCE, B_OPEN);
            1: do_write(S_CLEAR, B_CLOSE);
            2: do_write(S_FORCE | S_CLEAR, B_OPEN | B_CLOSE);
            default: do_write(S_FORCE | S_CLEAR, 32'hFFFF_EEFD);
          endcase
          check({tag, " start"}, 32'(init_start), 32'(exp_init));
          check({tag, " busy"}, 32'(busy), 32'(exp_init));

          if (exp_init) begin
            check({tag, " grant held"}, 32'(granted), 32'(s));
            do_write(S_FORCE | S_CLEAR, B_OPEN | B_CLOSE);
            check("R9 request ignored while busy", 32'(init_start), 0);
            if (k % 3 == 0) begin
              check("R2 still busy", 32'(busy), 1);
              pulse('1);
            end else begin
              for (int j = 0; j < N; j++) begin
                int idx;
                idx = (k % 2) ? ((k - j) % N + N) % N : (k + j) % N;
                if (j == N - 1) begin
                  check({tag, " busy before last done"}, 32'(busy), 1);
                  check({tag, " grant before last done"}, 32'(granted), 32'(s));
                end
                pulse(N'(1) << idx);
              end
            end
            check({tag, " busy end"}, 32'(busy), 0);
          end

          check({tag, " grant"}, 32'(granted), 32'(exp_open));
          check("R1 start idle", 32'(init_start), 0);
          rd(0, v); check("R8 status bit", v, exp_open ? 32'h2 : 0);
          rd(1, v); check("R4 R7 force readback", v, exp_wipe ? B_WIPE : 0);
          rd(2, v); check("R3 clear readback", v, 0);
        end

    // R12: stale done pulses are not counted
    do_reset();
    pulse('1);
    do_write(S_FORCE, B_OPEN);
    check("R12 start", 32'(init_start), 1);
    for (int j = 1; j < N; j++) pulse(N'(1) << j);
    check("R12 still busy", 32'(busy), 1);
    check("R12 not granted", 32'(granted), 0);
    pulse(N'(1));
    check("R12 granted", 32'(granted), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule